// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Period Limit

The block is a 16-bit up-counter that runs in single-slope PWM mode and drives two compare channels. The counter advances once per cycle in which the tick-enable input is high; an external prescaler or divider provides that tick. It climbs to a period limit and then clears to zero on the next tick. The limit is selected by a control field. It can be a fixed 8-, 9- or 10-bit full-scale value, an unbuffered capture/limit register, or the active compare value of channel A.

Each channel has a compare buffer that software writes. The buffer is copied into the active compare value only on the tick in which the counter sits at the limit. Because of this, duty and period updates never tear a period. The capture/limit register takes effect at once. If it is lowered below the running count, the counter misses the limit, runs up to 0xFFFF and wraps through zero before it can match again.

Each channel produces a PWM pin in non-inverted or inverted polarity. The pin is gated by a direction input. Four sticky flags report the limit, the two compare matches and the limit taken from the capture register. Each flag is cleared by writing a one to it.

Top module: `fpwm_timer`

## Requirements
- R1: After reset, `count` is 0, `flags` is 0, both PWM pins are 0, and every internal register (both compare buffers, both active compare values, the capture/limit register and the control register) is 0.
- R2: A write (`wr_en` high) stores `wr_data` by `wr_addr`: 0 = channel A compare buffer, 1 = channel B compare buffer, 2 = capture/limit register, 3 = control (bits [2:0] limit select, bits [4:3] channel A output mode, bits [6:5] channel B output mode), 4 = flag clear. `count` changes only in cycles where `tick` is high, and then by exactly one unless it is at the limit.
- R3: Limit select 0, 1 and 2 gives a limit of 255, 511 and 1023. Select 3 takes the capture/limit register, and select 4 takes channel A's active compare value; values 5 to 7 act as 0. On a tick with `count` equal to the limit, `count` becomes 0.
- R4: When the limit select is 0, 1 or 2, a compare write keeps only the low 8, 9 or 10 bits of `wr_data` and forces the upper bits to zero.
- R5: A compare write lands in the buffer only. The active compare value is loaded from the buffer on the tick where `count` equals the limit, so a write made mid-period leaves the current period unchanged (visible as the period length when the limit is channel A).
- R6: The capture/limit register acts immediately. If it is set below the current count, the counter runs up to 0xFFFF, wraps to 0, and sets no overflow flag on the way.
- R7: Flag bit 0 (overflow) is set on the tick where `count` equals the limit. Flag bit 3 is set on that same tick when the limit select is 3. With limit select 4, flag bit 1 rises together with bit 0.
- R8: Flag bit 1 (channel A) and flag bit 2 (channel B) are set on a tick where `count` equals the channel's active compare value. A compare value above the limit never sets its flag.
- R9: Output mode 2 is non-inverted. The pin goes high when the counter returns to 0 and goes low after the tick that matches the compare value, so it is high for compare+1 counts of each period. A compare value equal to the limit keeps the pin high all period.
- R10: Output mode 3 gives the exact complement of the mode-2 waveform.
- R11: A pin is 0 when its direction input is 0 or its output mode is 0 or 1. Pin A is also held at 0 while the limit select is 4.
- R12: A write to address 4 clears each flag whose `wr_data` bit is 1. If a flag's set event falls in the same cycle as its clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | 16 | Write data |
| dir_a | input | 1 | Channel A pin direction, 1 = output |
| dir_b | input | 1 | Channel B pin direction, 1 = output |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| flags | output | 4 | Sticky flags: [0] overflow, [1] match A, [2] match B, [3] limit from capture |

## Verification
Some rules can be checked on every cycle, and assertions cover them: the counter holds without a tick, steps by one, and clears after the limit. The overflow flag rises only as the counter clears, and with channel A as the limit both flags rise together. Pins stay silent when their direction is low or channel A defines the limit, and a plain one-write clears a flag. Other behaviour only shows over whole periods, so the bench scenarios must cover it: the masking of compare writes, the duty and polarity of the waveforms, the deferred load of the compare buffer, the long wrap through 0xFFFF after a missed limit, a compare above the limit that never fires, and the set-wins collision on a flag clear.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int NCH   = 2;
  localparam int NFLAG = NCH + 2;

  localparam int FLG_OVF = 0;
  localparam int FLG_CAP = NCH + 1;

  localparam logic [2:0] ADDR_CAP  = 3'(NCH);
  localparam logic [2:0] ADDR_CTRL = 3'(NCH + 1);
  localparam logic [2:0] ADDR_FLAG = 3'(NCH + 2);

  localparam int CTRL_MODE_LSB = 3;

  typedef enum logic [2:0] {
    TOP_FIX8  = 3'd0,
    TOP_FIX9  = 3'd1,
    TOP_FIX10 = 3'd2,
    TOP_CAP   = 3'd3,
    TOP_CHA   = 3'd4
  } top_sel_e;

  function automatic top_sel_e legal_sel(input logic [2:0] v);
    case (v)
      3'd1:    return TOP_FIX9;
      3'd2:    return TOP_FIX10;
      3'd3:    return TOP_CAP;
      3'd4:    return TOP_CHA;
      default: return TOP_FIX8;
    endcase
  endfunction
endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs
  import fpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [W-1:0]           wr_data,
  output logic [NCH-1:0][W-1:0]  cmp_buf,
  output logic [W-1:0]           cap_q,
  output top_sel_e               top_sel,
  output logic [NCH-1:0][1:0]    mode,
  output logic [NFLAG-1:0]       flag_clr
);
  localparam logic [W-1:0] MASK8  = {{(W-8){1'b0}},  8'hFF};
  localparam logic [W-1:0] MASK9  = {{(W-9){1'b0}},  9'h1FF};
  localparam logic [W-1:0] MASK10 = {{(W-10){1'b0}}, 10'h3FF};

  logic [W-1:0] wmask;

  always_comb begin
    case (top_sel)
      TOP_FIX8:  wmask = MASK8;
      TOP_FIX9:  wmask = MASK9;
      TOP_FIX10: wmask = MASK10;
      default:   wmask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cap_q   <= '0;
      top_sel <= TOP_FIX8;
      mode    <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == 3'(i)) cmp_buf[i] <= wr_data & wmask;
      end
      if (wr_addr == ADDR_CAP) cap_q <= wr_data;
      if (wr_addr == ADDR_CTRL) begin
        top_sel <= legal_sel(wr_data[2:0]);
        for (int i = 0; i < NCH; i++) begin
          mode[i] <= wr_data[CTRL_MODE_LSB + 2*i +: 2];
        end
      end
    end
  end

  assign flag_clr = (wr_en && wr_addr == ADDR_FLAG) ? wr_data[NFLAG-1:0] : '0;
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         to_bottom
);
  assign at_top    = (cnt == top_val);
  assign to_bottom = at_top | (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         at_top,
  input  logic         to_bottom,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] buf_val,
  input  logic [1:0]   mode,
  input  logic         dir,
  input  logic         mute,
  output logic [W-1:0] act,
  output logic         hit,
  output logic         pin
);
  logic level;

  assign hit = tick && (cnt == act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= '0;
      level <= 1'b0;
    end else begin
      if (tick && at_top)         act   <= buf_val;
      if (tick && to_bottom)      level <= 1'b1;
      else if (hit)               level <= 1'b0;
    end
  end

  assign pin = dir && !mute && mode[1] && (level ^ mode[0]);
endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags
  import fpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             dir_a,
  input  logic             dir_b,
  output logic [W-1:0]     count,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [NFLAG-1:0] flags
);
  localparam logic [W-1:0] TOP8  = {{(W-8){1'b0}},  8'hFF};
  localparam logic [W-1:0] TOP9  = {{(W-9){1'b0}},  9'h1FF};
  localparam logic [W-1:0] TOP10 = {{(W-10){1'b0}}, 10'h3FF};

  logic [NCH-1:0][W-1:0] cmp_buf;
  logic [NCH-1:0][W-1:0] cmp_act;
  logic [NCH-1:0][1:0]   mode;
  logic [NCH-1:0]        hit, pin, dir;
  logic [W-1:0]          cap_q, top_val;
  logic [NFLAG-1:0]      flag_clr, flag_set;
  logic                  at_top, to_bottom;
  top_sel_e              top_sel;

  fpwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_buf(cmp_buf), .cap_q(cap_q),
    .top_sel(top_sel), .mode(mode), .flag_clr(flag_clr)
  );

  always_comb begin
    case (top_sel)
      TOP_FIX9:  top_val = TOP9;
      TOP_FIX10: top_val = TOP10;
      TOP_CAP:   top_val = cap_q;
      TOP_CHA:   top_val = cmp_act[0];
      default:   top_val = TOP8;
    endcase
  end

  fpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_val(top_val),
    .cnt(count), .at_top(at_top), .to_bottom(to_bottom)
  );

  assign dir = {dir_b, dir_a};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fpwm_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top),
      .to_bottom(to_bottom), .cnt(count), .buf_val(cmp_buf[i]),
      .mode(mode[i]), .dir(dir[i]),
      .mute((i == 0) && (top_sel == TOP_CHA)),
      .act(cmp_act[i]), .hit(hit[i]), .pin(pin[i])
    );
    assign flag_set[1 + i] = hit[i];
  end

  assign flag_set[FLG_OVF] = tick && at_top;
  assign flag_set[FLG_CAP] = tick && at_top && (top_sel == TOP_CAP);

  fpwm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flags)
  );

  assign pwm_a = pin[0];
  assign pwm_b = pin[1];
endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk
  import fpwm_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [W-1:0]     wr_data,
  input logic             dir_a,
  input logic             dir_b,
  input logic [W-1:0]     count,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [NFLAG-1:0] flags,
  input logic             at_top,
  input top_sel_e         top_sel
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_top) |=> count == W'($past(count) + 1'b1));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_top) |=> count == '0);

  // R7
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLG_OVF]) |-> count == '0);

  // R7
  cha_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_sel == TOP_CHA && tick && at_top) |=> (flags[FLG_OVF] && flags[1]));

  // R11
  dir_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_a |-> !pwm_a);

  // R11
  dir_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_b |-> !pwm_b);

  // R11
  cha_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_sel == TOP_CHA) |-> !pwm_a);

  // R12
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_FLAG && wr_data[FLG_OVF] && !(tick && at_top))
      |=> !flags[FLG_OVF]);
endmodule

bind fpwm_timer fpwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .dir_a(dir_a), .dir_b(dir_b), .count(count),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags), .at_top(at_top),
  .top_sel(top_sel)
);

// File: tb/tb_fpwm_timer.sv
`timescale 1ns/1ps
module tb_fpwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        dir_a = 1'b1;
  logic        dir_b = 1'b1;
  logic [15:0] count;
  logic        pwm_a, pwm_b;
  logic [3:0]  flags;

  always #2 clk = ~clk;

  fpwm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dir_a(dir_a), .dir_b(dir_b), .count(count),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // scoreboard queues
  string       tag_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] obs_q[$];

  task automatic expect_item(input string tag, input logic [31:0] e);
    tag_q.push_back(tag);
    exp_q.push_back(e);
  endtask

  task automatic observe(input logic [31:0] a);
    obs_q.push_back(a);
  endtask

  task automatic score(input string tag, input logic [31:0] a, input logic [31:0] e);
    expect_item(tag, e);
    observe(a);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        string       t;
        logic [31:0] e, a;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        a = obs_q.pop_front();
        n_chk++;
        if (a !== e) begin
          n_err++;
          $display("FAIL %s actual=%0d expected=%0d", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr_now(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic wait_count(input logic [15:0] v);
    do @(negedge clk); while (count !== v);
  endtask

  task automatic measure(input bit ch_b, input int n, output int hi);
    wait_count(16'd0);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      hi += ch_b ? int'(pwm_b) : int'(pwm_a);
      @(negedge clk);
    end
  endtask

  task automatic max_period(output int mx);
    wait_count(16'd0);
    mx = 0;
    do begin
      @(negedge clk);
      if (int'(count) > mx) mx = int'(count);
    end while (count !== 16'd0);
  endtask

  task automatic resync();
    wait_count(16'd5);
    wait_count(16'd1);
  endtask

  int v;

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    score("R1 count", count, 0);
    score("R1 flags", flags, 0);
    score("R1 pwm_a", pwm_a, 0);
    score("R1 pwm_b", pwm_b, 0);

    // R2 tick enable gating
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    score("R2 five ticks", count, 5);
    repeat (10) @(negedge clk);
    score("R2 hold without tick", count, 5);
    tick = 1'b1;

    // R4 R9 R3: fixed 8-bit limit, mode 2 on B, masked compare
    wr(3'd3, 16'h0040);
    wr(3'd1, 16'h1234);
    measure(1'b1, 256, v);
    score("R4 R9 masked duty", v, 53);
    max_period(v);
    score("R3 fixed8 limit", v, 255);

    // R10 inverted
    wr(3'd3, 16'h0060);
    measure(1'b1, 256, v);
    score("R10 inverted duty", v, 203);

    // R11 direction gating
    dir_b = 1'b0;
    measure(1'b1, 256, v);
    score("R11 dir low", v, 0);
    dir_b = 1'b1;

    // R4 R9 R3: 9-bit limit, compare equal to limit
    wr(3'd3, 16'h0041);
    wr(3'd1, 16'hFFFF);
    measure(1'b1, 512, v);
    score("R4 R9 compare at limit", v, 512);
    max_period(v);
    score("R3 fixed9 limit", v, 511);

    // capture register as limit
    wr(3'd2, 16'd99);
    wr(3'd0, 16'd49);
    wr(3'd1, 16'd200);
    resync();
    wr_now(3'd3, 16'h0053);
    measure(1'b0, 100, v);
    score("R9 capture-limit duty A", v, 50);
    measure(1'b1, 100, v);
    score("R8 R9 compare above limit stays high", v, 100);
    max_period(v);
    score("R3 capture limit", v, 99);

    // R8 compare above limit never flags
    wait_count(16'd10);
    wr_now(3'd4, 16'h000F);
    repeat (250) @(negedge clk);
    score("R8 match B never", flags[2], 0);
    score("R8 match A set", flags[1], 1);

    // R7 overflow with capture-limit flag
    wait_count(16'd10);
    wr_now(3'd4, 16'h000F);
    do @(negedge clk); while (flags[0] !== 1'b1);
    score("R7 capture flag with ovf", flags[3], 1);
    score("R7 ovf at wrap", count, 0);

    // R12 clear and set-wins
    wait_count(16'd50);
    wr_now(3'd4, 16'h0001);
    score("R12 clear", flags[0], 0);
    wait_count(16'd99);
    wr_now(3'd4, 16'h0001);
    score("R12 set wins", flags[0], 1);

    // R6 missed limit
    wr(3'd2, 16'd999);
    wait_count(16'd600);
    wr_now(3'd2, 16'd100);
    wr_now(3'd4, 16'h000F);
    wait_count(16'hFFFF);
    score("R6 no ovf during run-out", flags[0], 0);
    @(negedge clk);
    score("R6 wrap to zero", count, 0);
    max_period(v);
    score("R6 new limit after wrap", v, 100);

    // R5 channel A as limit, buffered
    resync();
    wr_now(3'd3, 16'h0054);
    wr_now(3'd0, 16'd99);
    max_period(v);
    score("R5 loaded limit", v, 99);
    measure(1'b0, 100, v);
    score("R11 pin A muted", v, 0);
    wait_count(16'd10);
    wr_now(3'd0, 16'd29);
    v = 0;
    do begin
      @(negedge clk);
      if (int'(count) > v) v = int'(count);
    end while (count !== 16'd0);
    score("R5 current period kept", v, 99);
    max_period(v);
    score("R5 next period uses buffer", v, 29);

    // R7 ovf and match A together
    wait_count(16'd5);
    wr_now(3'd4, 16'h000F);
    do @(negedge clk); while (flags[0] !== 1'b1);
    score("R7 match A with ovf", flags[1], 1);
    score("R7 pair at wrap", count, 0);

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule